// File: doc/BRIEF.md
# Group Completion Table

This block keeps an ordered record of the instruction groups that a dispatch stage has sent into the machine. It is a ring of twenty slots. Each slot is one group. A slot is claimed when a group is dispatched and released when that group retires. Groups retire in exactly the order they were claimed. An execution stage reports each finished group by its tag. The table retires the oldest slot once that slot has been reported finished.

Beside the ring, the table holds one interlock bit for a resource that is not renamed. A group that writes this resource sets the bit when it is dispatched. The bit clears when that group retires. While the bit is set, any new group that touches the resource is held back. A one-hot "oldest" vector marks the slot that is next to retire, so that such a group can wait until every older group has gone. A flush keeps a chosen slot and every slot older than it, and frees all younger slots.

Top module: `group_cpl_table`

## Requirements
- R1: After reset the table is empty: `occupancy` is 0, `sb_busy` is 0, `retire_valid` is 0, `oldest_vec` is all zeros and the first tag granted is 0.
- R2: Accepted groups receive tags in rising order 0, 1, ... 19 and then wrap to 0. `alloc_tag` shows the tag granted in the same cycle as `alloc_ok`.
- R3: In each cycle at most one group is accepted and at most one retires. `occupancy` rises by one for each acceptance and falls by one for each retirement, so an acceptance and a retirement in the same cycle leave it unchanged.
- R4: A request is refused while all 20 slots are in use.
- R5: `retire_valid` is high only when the oldest slot is in use and has been reported finished. The rise comes in the cycle after the completion report. Tags retire in acceptance order, even when younger groups finish first.
- R6: An accepted group that has `alloc_sb_set` high makes `sb_busy` high from the next cycle. `sb_busy` falls in the cycle after that group retires.
- R7: While `sb_busy` is high, a request with `alloc_sb_use` or `alloc_sb_set` high is refused. A request with both flags low is still accepted.
- R8: `oldest_vec` has exactly one bit set, at the position equal to the oldest tag, whenever the table is not empty. It is all zeros when the table is empty.
- R9: A flush to tag F keeps F and every older slot and frees every younger slot. The next accepted group receives tag F+1, modulo 20.
- R10: A flush clears `sb_busy` when the group that set it was younger than F. It leaves `sb_busy` set when that group is F or older.
- R11: In a flush cycle, no request is accepted and no group retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | A group asks for a slot |
| alloc_sb_set | input | 1 | The requesting group writes the non-renamed resource |
| alloc_sb_use | input | 1 | The requesting group reads the non-renamed resource |
| alloc_ok | output | 1 | The request is accepted this cycle |
| alloc_tag | output | 5 | Tag granted to the request |
| cpl_valid | input | 1 | An execution stage reports a finished group |
| cpl_tag | input | 5 | Tag of the finished group |
| retire_valid | output | 1 | The oldest group retires this cycle |
| retire_tag | output | 5 | Tag of the retiring group |
| flush_req | input | 1 | Free every slot younger than `flush_tag` |
| flush_tag | input | 5 | Youngest slot to keep in a flush |
| sb_busy | output | 1 | Interlock bit for the non-renamed resource |
| occupancy | output | 5 | Number of slots in use |
| oldest_vec | output | 20 | One-hot marker of the next slot to retire |

## Verification
A wrong head pointer or a wrong done flag appears at once on `retire_tag`. It shows up the first time a group retires out of acceptance order, and the retire-order queue catches it in that cycle. A wrong tail pointer or a wrong count shows up on the next `alloc_tag` or in `occupancy` as soon as a request, a refusal at the full boundary or a flush follows. If the interlock owner is lost, `sb_busy` stays high or drops early. This is seen one cycle after the owning group retires or is flushed, and is checked both through `sb_busy` and through which requests are refused.

// File: rtl/gct_pkg.sv
package gct_pkg;

  // next slot index on a ring of n slots
  function automatic int unsigned ring_next(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // distance of a tag from the head, counted in acceptance order
  function automatic int unsigned ring_age(int unsigned tag, int unsigned head, int unsigned n);
    return (tag >= head) ? tag - head : tag + n - head;
  endfunction

endpackage

// File: rtl/gct_ring_ctl.sv
module gct_ring_ctl #(
  parameter int unsigned N  = 20,
  parameter int unsigned TW = 5,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_alloc,
  input  logic          do_retire,
  input  logic          flush_req,
  input  logic [TW-1:0] flush_tag,
  output logic [TW-1:0] head,
  output logic [TW-1:0] tail,
  output logic [CW-1:0] count
);
  import gct_pkg::*;

  logic [TW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_req) begin
      tail_q <= TW'(ring_next(32'(flush_tag), N));
      cnt_q  <= CW'(ring_age(32'(flush_tag), 32'(head_q), N) + 1);
    end else begin
      if (do_alloc)  tail_q <= TW'(ring_next(32'(tail_q), N));
      if (do_retire) head_q <= TW'(ring_next(32'(head_q), N));
      if (do_alloc && !do_retire)      cnt_q <= cnt_q + 1'b1;
      else if (!do_alloc && do_retire) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= N); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_req |=> (32'(cnt_q) <= 32'($past(cnt_q)) + 1) && (32'(cnt_q) + 1 >= 32'($past(cnt_q)))); // R3

endmodule

// File: rtl/gct_flags.sv
module gct_flags #(
  parameter int unsigned N  = 20,
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_alloc,
  input  logic [TW-1:0] tail,
  input  logic          alloc_sb_set,
  input  logic          cpl_hit,
  input  logic [TW-1:0] cpl_tag,
  output logic [N-1:0]  done_vec,
  output logic [N-1:0]  sbs_vec
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic done_q, sbs_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        sbs_q  <= 1'b0;
      end else if (do_alloc && tail == TW'(i)) begin
        done_q <= 1'b0;
        sbs_q  <= alloc_sb_set;
      end else if (cpl_hit && cpl_tag == TW'(i)) begin
        done_q <= 1'b1;
      end
    end
    assign done_vec[i] = done_q;
    assign sbs_vec[i]  = sbs_q;
  end

  AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |=> !done_vec[$past(tail)]); // R5

endmodule

// File: rtl/gct_sb.sv
module gct_sb #(
  parameter int unsigned N  = 20,
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [TW-1:0] set_tag,
  input  logic          retire_en,
  input  logic          retire_is_owner,
  input  logic          flush_req,
  input  logic [TW-1:0] flush_tag,
  input  logic [TW-1:0] head,
  output logic          busy
);
  import gct_pkg::*;

  logic          busy_q;
  logic [TW-1:0] owner_q;
  logic          owner_flushed;

  assign owner_flushed = flush_req && busy_q &&
    (ring_age(32'(owner_q), 32'(head), N) > ring_age(32'(flush_tag), 32'(head), N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (owner_flushed) begin
      busy_q <= 1'b0;
    end else if (retire_en && retire_is_owner) begin
      busy_q <= 1'b0;
    end else if (set_en) begin
      busy_q  <= 1'b1;
      owner_q <= set_tag;
    end
  end

  assign busy = busy_q;

  AST_SB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy); // R6
  AST_SB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !set_en); // R7

endmodule

// File: rtl/group_cpl_table.sv
module group_cpl_table #(
  parameter int unsigned N  = 20,
  parameter int unsigned TW = $clog2(N),
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          alloc_sb_set,
  input  logic          alloc_sb_use,
  output logic          alloc_ok,
  output logic [TW-1:0] alloc_tag,
  input  logic          cpl_valid,
  input  logic [TW-1:0] cpl_tag,
  output logic          retire_valid,
  output logic [TW-1:0] retire_tag,
  input  logic          flush_req,
  input  logic [TW-1:0] flush_tag,
  output logic          sb_busy,
  output logic [CW-1:0] occupancy,
  output logic [N-1:0]  oldest_vec
);
  import gct_pkg::*;

  logic [TW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [N-1:0]  done_vec, sbs_vec;
  logic          full, empty, sb_block, cpl_hit;

  assign full     = (32'(count) == N);
  assign empty    = (count == '0);
  assign sb_block = sb_busy && (alloc_sb_use || alloc_sb_set);
  assign alloc_ok = alloc_req && !full && !sb_block && !flush_req;
  assign alloc_tag = tail;

  assign retire_valid = !empty && done_vec[head] && !flush_req;
  assign retire_tag   = head;

  assign cpl_hit = cpl_valid && (32'(cpl_tag) < N) &&
                   (ring_age(32'(cpl_tag), 32'(head), N) < 32'(count));

  assign occupancy = count;

  for (genvar i = 0; i < N; i++) begin : g_oldest
    assign oldest_vec[i] = !empty && (head == TW'(i));
  end

  gct_ring_ctl #(.N(N), .TW(TW), .CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_n), .do_alloc(alloc_ok), .do_retire(retire_valid),
    .flush_req(flush_req), .flush_tag(flush_tag),
    .head(head), .tail(tail), .count(count)
  );

  gct_flags #(.N(N), .TW(TW)) u_flags (
    .clk(clk), .rst_n(rst_n), .do_alloc(alloc_ok), .tail(tail),
    .alloc_sb_set(alloc_sb_set), .cpl_hit(cpl_hit), .cpl_tag(cpl_tag),
    .done_vec(done_vec), .sbs_vec(sbs_vec)
  );

  gct_sb #(.N(N), .TW(TW)) u_sb (
    .clk(clk), .rst_n(rst_n), .set_en(alloc_ok && alloc_sb_set), .set_tag(tail),
    .retire_en(retire_valid), .retire_is_owner(sbs_vec[head]),
    .flush_req(flush_req), .flush_tag(flush_tag), .head(head), .busy(sb_busy)
  );

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ok); // R4
  AST_RETIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> !empty); // R5
  AST_SB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_busy && alloc_sb_use) |-> !alloc_ok); // R7
  AST_OLDEST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oldest_vec)); // R8
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (!alloc_ok && !retire_valid)); // R11

endmodule

// File: tb/tb_group_cpl_table.sv
`timescale 1ns/1ps
module tb_group_cpl_table;
  localparam int NS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 0, alloc_sb_set = 0, alloc_sb_use = 0;
  logic cpl_valid = 0, flush_req = 0;
  logic [4:0] cpl_tag = '0, flush_tag = '0;
  logic alloc_ok, retire_valid, sb_busy;
  logic [4:0] alloc_tag, retire_tag, occupancy;
  logic [NS-1:0] oldest_vec;

  int total = 0, bad = 0;
  int exp_q[$];
  int exp_tail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  group_cpl_table dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_sb_set(alloc_sb_set),
    .alloc_sb_use(alloc_sb_use), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .retire_valid(retire_valid),
    .retire_tag(retire_tag), .flush_req(flush_req), .flush_tag(flush_tag),
    .sb_busy(sb_busy), .occupancy(occupancy), .oldest_vec(oldest_vec)
  );

  function automatic int nxt(int t);
    return (t == NS - 1) ? 0 : t + 1;
  endfunction

  task automatic chk(bit ok, string rq, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: every retirement must match the oldest expected tag (R5)
  always @(negedge clk) begin
    #2;
    if (rst_n && retire_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 retire on empty model", int'(retire_tag), -1);
      else begin
        chk(int'(retire_tag) == exp_q[0], "R5 retire order", int'(retire_tag), exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic do_alloc(bit s, bit u, bit want, string rq);
    alloc_req = 1; alloc_sb_set = s; alloc_sb_use = u;
    #1;
    chk(alloc_ok == want, rq, int'(alloc_ok), int'(want));
    if (alloc_ok) begin
      chk(int'(alloc_tag) == exp_tail, "R2 granted tag", int'(alloc_tag), exp_tail);
      exp_q.push_back(int'(alloc_tag));
      exp_tail = nxt(exp_tail);
    end
    tick();
    alloc_req = 0; alloc_sb_set = 0; alloc_sb_use = 0;
  endtask

  task automatic do_cpl(int t);
    cpl_valid = 1; cpl_tag = 5'(t);
    tick();
    cpl_valid = 0;
  endtask

  task automatic do_flush(int f);
    flush_req = 1; flush_tag = 5'(f); alloc_req = 1;
    #1;
    chk(alloc_ok == 0, "R11 no accept in flush", int'(alloc_ok), 0);
    chk(retire_valid == 0, "R11 no retire in flush", int'(retire_valid), 0);
    while (exp_q.size() > 0 && exp_q[$] != f) void'(exp_q.pop_back());
    exp_tail = nxt(f);
    tick();
    flush_req = 0; alloc_req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int cp[$];
    idle(3);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(occupancy == 0, "R1 occupancy", int'(occupancy), 0);
    chk(sb_busy == 0, "R1 sb_busy", int'(sb_busy), 0);
    chk(retire_valid == 0, "R1 retire_valid", int'(retire_valid), 0);
    chk(oldest_vec == '0, "R1 R8 oldest_vec empty", int'(oldest_vec), 0);
    chk(alloc_tag == 0, "R1 first tag", int'(alloc_tag), 0);

    // R2 in-order tags, R5 younger finishing first does not retire
    do_alloc(0, 0, 1, "R2 accept");
    do_alloc(0, 0, 1, "R2 accept");
    do_alloc(0, 0, 1, "R2 accept");
    #1;
    chk(occupancy == 3, "R3 occupancy", int'(occupancy), 3);
    chk(oldest_vec == 20'h1, "R8 oldest at tag 0", int'(oldest_vec), 1);
    do_cpl(1);
    #1;
    chk(retire_valid == 0, "R5 head not done", int'(retire_valid), 0);
    do_cpl(0);
    do_cpl(2);
    idle(4);
    #1;
    chk(occupancy == 0, "R5 drained", int'(occupancy), 0);

    // R4 fill to 20 with wrap, then refuse
    for (int i = 0; i < NS; i++) do_alloc(0, 0, 1, "R4 accept while room");
    do_alloc(0, 0, 0, "R4 refuse when full");
    #1;
    chk(occupancy == 20, "R4 occupancy full", int'(occupancy), 20);
    cp = exp_q;
    for (int i = NS - 1; i >= 0; i--) do_cpl(cp[i]);
    idle(NS + 4);
    #1;
    chk(occupancy == 0, "R5 drained after reverse finish", int'(occupancy), 0);

    // R3 accept and retire in the same cycle
    do_alloc(0, 0, 1, "R3 accept");
    do_cpl(exp_q[0]);
    #1;
    chk(retire_valid == 1, "R5 retire one cycle after report", int'(retire_valid), 1);
    do_alloc(0, 0, 1, "R3 accept with retire");
    #1;
    chk(occupancy == 1, "R3 simultaneous keeps count", int'(occupancy), 1);
    do_cpl(exp_q[0]);
    idle(3);

    // R6 R7 interlock
    do_alloc(1, 0, 1, "R6 owner accept");
    #1;
    chk(sb_busy == 1, "R6 set after accept", int'(sb_busy), 1);
    do_alloc(0, 1, 0, "R7 reader held");
    do_alloc(1, 0, 0, "R7 writer held");
    do_alloc(0, 0, 1, "R7 plain accepted");
    #1;
    chk(oldest_vec == (20'h1 << exp_q[0]), "R8 oldest is owner", int'(oldest_vec), 1 << exp_q[0]);
    do_cpl(exp_q[0]);
    #1;
    chk(sb_busy == 1, "R6 held until retire", int'(sb_busy), 1);
    tick();
    #1;
    chk(sb_busy == 0, "R6 cleared after retire", int'(sb_busy), 0);
    do_cpl(exp_q[0]);
    idle(3);

    // R9 R10 flush
    begin
      int a;
      a = exp_tail;
      do_alloc(0, 0, 1, "R9 setup");
      do_alloc(1, 0, 1, "R10 owner");
      do_alloc(0, 0, 1, "R9 setup");
      do_flush(a);
      #1;
      chk(occupancy == 1, "R9 younger freed", int'(occupancy), 1);
      chk(sb_busy == 0, "R10 owner flushed", int'(sb_busy), 0);
      do_alloc(0, 0, 1, "R9 accept after flush");
      do_alloc(1, 0, 1, "R10 owner kept");
      a = exp_q[$];
      do_alloc(0, 0, 1, "R9 setup");
      do_flush(a);
      #1;
      chk(sb_busy == 1, "R10 owner survives", int'(sb_busy), 1);
      chk(occupancy == 3, "R9 count after flush", int'(occupancy), 3);
      cp = exp_q;
      foreach (cp[i]) do_cpl(cp[i]);
      idle(5);
      #1;
      chk(sb_busy == 0, "R6 cleared at end", int'(sb_busy), 0);
      chk(occupancy == 0, "R3 final empty", int'(occupancy), 0);
      chk(exp_q.size() == 0, "R5 all retired", exp_q.size(), 0);
    end
    summary();
  end
endmodule